// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

The block is a general purpose I/O controller for sixteen pins, organised as two banks of eight and reached over a simple byte-wide register port. Each pin owns a pad control register, which holds direction, drive type, pull settings and output level, and a sense register, which reports the synchronised pin level and chooses which input edges count as interrupt events. The pad settings leave the block as plain control outputs for the pad ring to use. The block contains no resistors and no pad drivers.

Each bank has a pending byte that records detected edges until software clears them by writing ones. Each bank also has an active-state mask byte that decides which pending bits drive the single level-sensitive interrupt output. A second mask byte per bank is kept for a low-power state. Software can read and write it, but it has no effect on the interrupt output. Software reads the pending bytes, writes the same values back to acknowledge them, and services the pins whose bits were set.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pad control and sense register reads 0x00 (input mode, no pull, edge detection off). All four mask bytes read 0xFF, both pending bytes read 0x00, and irq, pin_oe and pin_out are low.
- R2: The pad control register of pin p (bank b = p/8, index i = p%8) is at address 0x2B + 0x10*b + i. Its sense register is at 0x33 + 0x10*b + i. A pad control read returns the six stored bits in [5:0] and zeros in [7:6].
- R3: Pad control bits: [0] output level, [2:1] pull choice (00 strong down, 01 strong up, 10 weak down, 11 weak up), [3] pull enable, [4] open drain, [5] output direction. pin_out, pull_sel, pull_en and pin_od follow these bits. pin_oe equals bit 5 AND NOT (bit 4 AND bit 0).
- R4: Sense register bit 0 reads the pin level two clock edges after the pin changes. Writes to bit 0 are ignored. Bits [2:1] store the edge code, and bits [7:3] always read zero.
- R5: Edge code 00 detects nothing, 01 detects falling edges, 10 rising edges and 11 both. A qualifying edge sets the pin's pending bit on the third clock edge after the pin changes.
- R6: Pending bytes are at 0x0B (bank 0) and 0x0C (bank 1), with bit i standing for pin index i. Writing a byte clears exactly the bits written as one and leaves the others unchanged.
- R7: When an edge event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R8: A pending bit sets on a qualifying edge even when the pin is masked.
- R9: Active-state masks are at 0x19 (bank 0) and 0x1A (bank 1), where a 1 masks the pin. irq is high exactly while some pending bit has its mask bit at 0.
- R10: Low-power masks at 0x1B and 0x1C can be read and written with the same bit-per-pin layout and never change irq.
- R11: Reads of unmapped addresses return 0x00, and bus_rdata is 0x00 whenever bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_re | input | 1 | Read enable; read data is combinational |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Output level per pin |
| pin_oe | output | 16 | Pad output enable per pin |
| pin_od | output | 16 | Open-drain select per pin |
| pull_en | output | 16 | Pull resistor enable per pin |
| pull_sel | output | 32 | Pull choice per pin, two bits per pin |
| irq | output | 1 | Combined level interrupt |

## Verification
A pending bit can be set by an edge and cleared by software in the same clock edge. The bench produces this collision by changing a pin that already has its bit pending, waiting two clock edges, and then issuing the clearing write so that it commits on the same edge that records the new event. The bit must still read as set afterwards, and a second clear must then remove it. A related overlap, a partial clear landing on a byte whose other bits stay pending, is judged by reading back the exact byte value.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Bit order matches the pad control register, bit 5 down to bit 0.
  typedef struct packed {
    logic       dir_out;
    logic       open_drain;
    logic       pull_on;
    logic [1:0] pull_kind;
    logic       level;
  } pad_ctrl_t;

  localparam int PAD_CTRL_W = $bits(pad_ctrl_t);

  localparam int ADDR_PEND_BASE   = 'h0B;
  localparam int ADDR_MASK_BASE   = 'h19;
  localparam int ADDR_LPMASK_BASE = 'h1B;
  localparam int ADDR_PAD_BASE    = 'h2B;
  localparam int ADDR_SENSE_BASE  = 'h33;
  localparam int BANK_STRIDE      = 'h10;

  function automatic logic [7:0] pad_addr(int bank, int idx);
    return 8'(ADDR_PAD_BASE + bank * BANK_STRIDE + idx);
  endfunction

  function automatic logic [7:0] sense_addr(int bank, int idx);
    return 8'(ADDR_SENSE_BASE + bank * BANK_STRIDE + idx);
  endfunction

  function automatic logic [7:0] pend_addr(int bank);
    return 8'(ADDR_PEND_BASE + bank);
  endfunction

  function automatic logic [7:0] mask_addr(int bank);
    return 8'(ADDR_MASK_BASE + bank);
  endfunction

  function automatic logic [7:0] lpmask_addr(int bank);
    return 8'(ADDR_LPMASK_BASE + bank);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pad_we,
  input  logic                  sense_we,
  input  logic [7:0]            wdata,
  input  logic                  pin_raw,
  output logic [PAD_CTRL_W-1:0] pad_bits,
  output logic [1:0]            edge_code,
  output logic                  level,
  output logic                  edge_evt,
  output logic                  pad_out,
  output logic                  pad_oe,
  output logic                  pad_od,
  output logic                  pad_pull_en,
  output logic [1:0]            pad_pull_sel
);

  pad_ctrl_t pad_q, pad_d;
  edge_sel_e esel_q, esel_d;
  logic      lvl_sync;
  logic      prev_q, prev_d;
  logic      rise, fall;

  gpio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (lvl_sync)
  );

  always_comb begin
    pad_d  = pad_q;
    esel_d = esel_q;
    prev_d = lvl_sync;
    if (pad_we) begin
      pad_d = pad_ctrl_t'(wdata[PAD_CTRL_W-1:0]);
    end
    if (sense_we) begin
      esel_d = edge_sel_e'(wdata[2:1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q  <= '0;
      esel_q <= EDGE_OFF;
      prev_q <= 1'b0;
    end else begin
      pad_q  <= pad_d;
      esel_q <= esel_d;
      prev_q <= prev_d;
    end
  end

  assign rise     = lvl_sync & ~prev_q;
  assign fall     = ~lvl_sync & prev_q;
  assign edge_evt = (esel_q[1] & rise) | (esel_q[0] & fall);

  assign pad_bits     = pad_q;
  assign edge_code    = esel_q;
  assign level        = lvl_sync;
  assign pad_out      = pad_q.level;
  assign pad_od       = pad_q.open_drain;
  assign pad_pull_en  = pad_q.pull_on;
  assign pad_pull_sel = pad_q.pull_kind;
  assign pad_oe       = pad_q.dir_out & ~(pad_q.open_drain & pad_q.level);

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic             pend_we,
  input  logic             mask_we,
  input  logic             lpmask_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] pend,
  output logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] lpmask,
  output logic             bank_irq
);

  logic [WIDTH-1:0] pend_q, pend_d;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic [WIDTH-1:0] lpm_q, lpm_d;
  logic [WIDTH-1:0] clr_bits;

  always_comb begin
    clr_bits = pend_we ? wdata : '0;
    // A new event overrides a clear of the same bit.
    pend_d   = (pend_q & ~clr_bits) | evt;
    mask_d   = mask_we   ? wdata : mask_q;
    lpm_d    = lpmask_we ? wdata : lpm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      lpm_q  <= '1;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      lpm_q  <= lpm_d;
    end
  end

  assign pend     = pend_q;
  assign mask     = mask_q;
  assign lpmask   = lpm_q;
  assign bank_irq = |(pend_q & ~mask_q);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [7:0]                      bus_addr,
  input  logic [7:0]                      bus_wdata,
  input  logic                            bus_we,
  input  logic                            bus_re,
  output logic [7:0]                      bus_rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_oe,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_od,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pull_en,
  output logic [2*NUM_BANKS*PINS_PER_BANK-1:0] pull_sel,
  output logic                            irq
);

  localparam int NPINS = NUM_BANKS * PINS_PER_BANK;

  logic core_rst_n;

  logic [PAD_CTRL_W-1:0] pad_bits_n [NPINS];
  logic [NPINS-1:0]      level_all;
  logic [NPINS-1:0]      evt_all;
  logic [2*NPINS-1:0]    esel_all;
  logic [NPINS-1:0]      pend_all;
  logic [NPINS-1:0]      mask_all;
  logic [NPINS-1:0]      lpmask_all;
  logic [NUM_BANKS-1:0]  bank_irq;
  logic [7:0]            rd_mux;

  // Reset: asserted asynchronously, released on the clock.
  gpio_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (core_rst_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
      localparam int N = b * PINS_PER_BANK + i;
      logic pad_we, sense_we;

      assign pad_we   = bus_we && (bus_addr == pad_addr(b, i));
      assign sense_we = bus_we && (bus_addr == sense_addr(b, i));

      gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk          (clk),
        .rst_n        (core_rst_n),
        .pad_we       (pad_we),
        .sense_we     (sense_we),
        .wdata        (bus_wdata),
        .pin_raw      (pin_in[N]),
        .pad_bits     (pad_bits_n[N]),
        .edge_code    (esel_all[2*N +: 2]),
        .level        (level_all[N]),
        .edge_evt     (evt_all[N]),
        .pad_out      (pin_out[N]),
        .pad_oe       (pin_oe[N]),
        .pad_od       (pin_od[N]),
        .pad_pull_en  (pull_en[N]),
        .pad_pull_sel (pull_sel[2*N +: 2])
      );
    end

    logic pend_we, mask_we, lpmask_we;
    assign pend_we   = bus_we && (bus_addr == pend_addr(b));
    assign mask_we   = bus_we && (bus_addr == mask_addr(b));
    assign lpmask_we = bus_we && (bus_addr == lpmask_addr(b));

    gpio_bank_irq #(.WIDTH(PINS_PER_BANK)) u_irq (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .evt       (evt_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pend_we   (pend_we),
      .mask_we   (mask_we),
      .lpmask_we (lpmask_we),
      .wdata     (bus_wdata[PINS_PER_BANK-1:0]),
      .pend      (pend_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .mask      (mask_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .lpmask    (lpmask_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .bank_irq  (bank_irq[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == pend_addr(b)) begin
        rd_mux = 8'(pend_all[b*PINS_PER_BANK +: PINS_PER_BANK]);
      end
      if (bus_addr == mask_addr(b)) begin
        rd_mux = 8'(mask_all[b*PINS_PER_BANK +: PINS_PER_BANK]);
      end
      if (bus_addr == lpmask_addr(b)) begin
        rd_mux = 8'(lpmask_all[b*PINS_PER_BANK +: PINS_PER_BANK]);
      end
      for (int i = 0; i < PINS_PER_BANK; i++) begin
        if (bus_addr == pad_addr(b, i)) begin
          rd_mux = 8'(pad_bits_n[b*PINS_PER_BANK + i]);
        end
        if (bus_addr == sense_addr(b, i)) begin
          rd_mux = {5'b0, esel_all[2*(b*PINS_PER_BANK + i) +: 2],
                    level_all[b*PINS_PER_BANK + i]};
        end
      end
    end
  end

  assign bus_rdata = bus_re ? rd_mux : 8'h00;
  assign irq       = |bank_irq;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 8
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic [7:0]                           bus_addr,
  input logic                                 bus_we,
  input logic                                 bus_re,
  input logic [7:0]                           bus_rdata,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_out,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_od,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pin_oe,
  input logic                                 irq,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pend_all,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   mask_all,
  input logic [2*NUM_BANKS*PINS_PER_BANK-1:0] esel_all
);

  localparam int NPINS = NUM_BANKS * PINS_PER_BANK;

  // R3: an open-drain pin driving high never has its driver enabled
  p_od_high_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_od & pin_out & pin_oe) == '0);

  // R9: with every active mask bit set the interrupt stays low
  p_all_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_all) |-> !irq);

  // R11: no read enable, no read data
  p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 8'h00));

  for (genvar n = 0; n < NPINS; n++) begin : g_pin_chk
    // R5: a pending bit only appears for a pin whose edge code is not off
    p_pend_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_all[n]) |-> ($past(esel_all[2*n +: 2]) != 2'b00));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R6: pending bits drop only after a write to that bank's pending byte
    p_pend_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend_all[b*PINS_PER_BANK +: PINS_PER_BANK]) &
         ~pend_all[b*PINS_PER_BANK +: PINS_PER_BANK]))
      |-> ($past(bus_we) && ($past(bus_addr) == pend_addr(b))));
  end

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .PINS_PER_BANK (PINS_PER_BANK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_od    (pin_od),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .pend_all  (pend_all),
  .mask_all  (mask_all),
  .esel_all  (esel_all)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_we;
  logic          bus_re;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pins;
  logic [NP-1:0] pin_out, pin_oe, pin_od, pull_en;
  logic [2*NP-1:0] pull_sel;
  logic          irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_in    (pins),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od),
    .pull_en   (pull_en),
    .pull_sel  (pull_sel),
    .irq       (irq)
  );

  function automatic logic [7:0] a_pad(int p);
    return 8'(8'h2B + (p / 8) * 16 + (p % 8));
  endfunction
  function automatic logic [7:0] a_sense(int p);
    return 8'(8'h33 + (p / 8) * 16 + (p % 8));
  endfunction
  function automatic logic [7:0] a_pend(int b);
    return 8'(8'h0B + b);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_re   = 1'b1;
    #1;
    d        = bus_rdata;
    bus_re   = 1'b0;
  endtask

  function automatic bit is_mapped(int a);
    return (a == 'h0B) || (a == 'h0C) || (a >= 'h19 && a <= 'h1C) ||
           (a >= 'h2B && a <= 'h4A);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0; pins = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1: reset state of every mapped register and the outputs
    for (int p = 0; p < NP; p++) begin
      bus_read(a_pad(p), rd);   check("R1 pad ctrl reset", rd, 8'h00);
      bus_read(a_sense(p), rd); check("R1 sense reset", rd, 8'h00);
    end
    for (int b = 0; b < 2; b++) begin
      bus_read(a_pend(b), rd);     check("R1 pending reset", rd, 8'h00);
      bus_read(8'(8'h19 + b), rd); check("R1 mask reset", rd, 8'hFF);
      bus_read(8'(8'h1B + b), rd); check("R1 lp mask reset", rd, 8'hFF);
    end
    check("R1 irq reset", irq, 0);
    check("R1 oe reset", pin_oe, 0);
    check("R1 out reset", pin_out, 0);

    // R2/R3: every pad control value on every pin
    for (int p = 0; p < NP; p++) begin
      for (int v = 0; v < 64; v++) begin
        logic [5:0] vb;
        logic       oe_exp;
        vb = 6'(v);
        oe_exp = vb[5] & ~(vb[4] & vb[0]);
        bus_write(a_pad(p), {2'b11, vb});
        bus_read(a_pad(p), rd);
        check("R2 pad ctrl readback", rd, {2'b00, vb});
        check("R3 pad outputs",
              {pin_oe[p], pin_od[p], pull_en[p], pull_sel[2*p +: 2], pin_out[p]},
              {oe_exp, vb[4], vb[3], vb[2:1], vb[0]});
        check("R3 oe isolated", pin_oe, 32'(oe_exp) << p);
      end
      bus_write(a_pad(p), 8'h00);
    end

    // R4/R5/R8/R6: every edge code on every pin, rising then falling
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] bit_p;
        bit_p = 8'(1 << (p % 8));
        bus_write(a_sense(p), 8'hF9 | 8'(m << 1));
        bus_read(a_sense(p), rd);
        check("R4 sense readback low", rd, 8'(m << 1));
        pins[p] = 1'b1;
        wait_cyc(2);
        bus_read(a_sense(p), rd);
        check("R4 level after sync", rd, 8'(m << 1) | 8'h01);
        wait_cyc(1);
        bus_read(a_pend(p / 8), rd);
        check("R5 rising edge pending", rd, ((m & 2) != 0) ? bit_p : 8'h00);
        check("R8 masked pin pends, irq low", irq, 0);
        bus_write(a_pend(p / 8), 8'hFF);
        bus_read(a_pend(p / 8), rd);
        check("R6 write ones clears", rd, 8'h00);
        pins[p] = 1'b0;
        wait_cyc(3);
        bus_read(a_pend(p / 8), rd);
        check("R5 falling edge pending", rd, ((m & 1) != 0) ? bit_p : 8'h00);
        bus_write(a_pend(p / 8), 8'hFF);
        bus_write(a_sense(p), 8'h00);
      end
    end

    // R6: partial clear in bank 1
    bus_write(a_sense(8), 8'h06);
    bus_write(a_sense(10), 8'h06);
    bus_write(a_sense(13), 8'h06);
    pins[8] = 1'b1; pins[10] = 1'b1; pins[13] = 1'b1;
    wait_cyc(3);
    bus_read(8'h0C, rd); check("R6 three pending", rd, 8'h25);
    bus_write(8'h0C, 8'h05);
    bus_read(8'h0C, rd); check("R6 partial clear", rd, 8'h20);

    // R9/R10: masks and interrupt
    check("R9 masked no irq", irq, 0);
    bus_write(8'h1A, 8'hDF); check("R9 unmask pending pin", irq, 1);
    bus_write(8'h19, 8'h00); check("R9 other bank unmask", irq, 1);
    bus_write(8'h1C, 8'hFF); check("R10 lp mask no effect", irq, 1);
    bus_write(8'h1B, 8'h5A);
    bus_read(8'h1B, rd); check("R10 lp mask readback", rd, 8'h5A);
    bus_read(8'h1C, rd); check("R10 lp mask readback b1", rd, 8'hFF);
    bus_write(8'h1A, 8'hFF); check("R9 remask", irq, 0);
    bus_write(8'h1A, 8'h00); check("R9 unmask all", irq, 1);

    // R7: clear and new edge on the same bit in the same cycle
    pins[13] = 1'b0;
    wait_cyc(2);
    bus_write(8'h0C, 8'hFF);
    bus_read(8'h0C, rd); check("R7 set wins over clear", rd, 8'h20);
    check("R7 irq still high", irq, 1);
    bus_write(8'h0C, 8'hFF);
    bus_read(8'h0C, rd); check("R7 later clear", rd, 8'h00);
    check("R9 irq drops after clear", irq, 0);

    // R11: unmapped addresses and idle read port
    for (int a = 0; a < 256; a++) begin
      if (!is_mapped(a)) begin
        bus_read(8'(a), rd);
        check("R11 unmapped read zero", rd, 8'h00);
      end
    end
    bus_addr = 8'h19; bus_re = 1'b0; #1;
    check("R11 idle read zero", bus_rdata, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule